// File: doc/BRIEF.md
# Multithreaded Atomic Entry Writer

This block is the write front end for a translation array whose entries have two 64-bit halves, a real-address half and an effective-address half. Up to four hardware threads share it, each on a request lane of its own. The lane number is the thread ID. A thread first stores its real-address half in a holding register that belongs only to it. It then sends the effective-address half together with an entry index. That second write is the commit: the block sends both halves to the array in a single write, so the array never holds a mix of old and new halves.

Two threads may commit in the same cycle. An arbiter then grants one commit per cycle. The arbiter gives fixed priority or rotating priority, chosen by a parameter. Each thread whose commit loses sees its busy flag and must hold its request. The array storage and the choice of index are outside this block. The index arrives with each commit.

Top module: `aew_entry_writer`

## Requirements
- R1: After reset, every holding register reads zero, `busy_o` is all zero and `wr_en_o` is low. A commit that follows with no holding write carries an all-zero real-address half.
- R2: A request with word select 1 loads the issuing thread's holding register and produces no array write. No other thread's holding register changes.
- R3: A commit is a request with word select 0 that is not stalled. Exactly one cycle after it is accepted, `wr_en_o` is high. `wr_tid_o` then carries the thread, `wr_idx_o` the request index, and `wr_epn_o` the request data.
- R4: The `wr_rpn_o` of a commit equals the value most recently loaded into that thread's holding register. A commit leaves the holding register unchanged, so later commits can reuse it.
- R5: At most one commit is accepted per cycle, so at most one array write is issued per cycle.
- R6: A commit request that is not granted raises that thread's `busy_o` in the same cycle. It produces no array write for that cycle.
- R7: With `ARB_MODE` set to rotating, the search order after a grant to thread g starts at g+1 modulo the thread count. Out of reset, thread 0 has top priority. With fixed mode, the lower thread number always wins.
- R8: A word-select-1 request is never stalled. Its `busy_o` stays low even while other threads' commits contend.
- R9: One thread may load its holding register in the same cycle that another thread's commit is accepted. The commit still carries the committing thread's own held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | NUM_THREADS | Request valid, one bit per thread lane |
| req_ws_i | input | NUM_THREADS | Word select per lane: 1 = real-address half, 0 = commit |
| req_data_i | input | NUM_THREADS*DATA_W | Data word per lane, lane t at bits [t*DATA_W +: DATA_W] |
| req_idx_i | input | NUM_THREADS*IDX_W | Entry index per lane |
| busy_o | output | NUM_THREADS | Commit stalled this cycle, hold the request |
| wr_en_o | output | 1 | Array write strobe |
| wr_tid_o | output | TID_W | Thread that owns the write |
| wr_idx_o | output | IDX_W | Entry index written |
| wr_epn_o | output | DATA_W | Effective-address half |
| wr_rpn_o | output | DATA_W | Real-address half |

## Verification
The bench builds the block with four threads, 64-bit data, a 4-bit index and rotating arbitration. With four lanes, all-four contention can happen, so the grant order visits every thread. It also lets a holding-register write on one lane coincide with a commit on another. Full 64-bit data shows any mix-up between halves or threads in the written entry. Rotating mode covers the pointer logic, which fixed mode would leave unused.

// File: rtl/aew_pkg.sv
package aew_pkg;
  typedef enum logic {
    ARB_FIXED  = 1'b0,
    ARB_ROTATE = 1'b1
  } arb_mode_e;

  function automatic int unsigned tid_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/aew_hold_bank.sv
module aew_hold_bank #(
  parameter int unsigned NT = 4,
  parameter int unsigned DW = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NT-1:0]    ld_i,
  input  logic [NT*DW-1:0] data_i,
  output logic [NT*DW-1:0] hold_o
);
  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic [DW-1:0] hold_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hold_q <= '0;
      else if (ld_i[t]) hold_q <= data_i[t*DW +: DW];
    end
    assign hold_o[t*DW +: DW] = hold_q;
  end
endmodule

// File: rtl/aew_commit_arb.sv
module aew_commit_arb
  import aew_pkg::*;
#(
  parameter int unsigned NT   = 4,
  parameter arb_mode_e   MODE = ARB_ROTATE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NT-1:0] req_i,
  output logic [NT-1:0] gnt_o
);
  localparam int unsigned TW = tid_width(NT);

  if (MODE == ARB_ROTATE) begin : g_rot
    logic [TW-1:0] last_q;
    logic [TW-1:0] last_d;
    logic          found;

    always_comb begin
      gnt_o  = '0;
      found  = 1'b0;
      last_d = last_q;
      for (int k = 0; k < int'(NT); k++) begin
        int idx;
        idx = (int'(last_q) + 1 + k) % int'(NT);
        if (!found && req_i[idx]) begin
          gnt_o[idx] = 1'b1;
          found      = 1'b1;
          last_d     = TW'(idx);
        end
      end
    end

    // thread 0 leads out of reset
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) last_q <= TW'(NT - 1);
      else         last_q <= last_d;
    end
  end else begin : g_fix
    logic found;
    always_comb begin
      gnt_o = '0;
      found = 1'b0;
      for (int k = 0; k < int'(NT); k++) begin
        if (!found && req_i[k]) begin
          gnt_o[k] = 1'b1;
          found    = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aew_commit_out.sv
module aew_commit_out
  import aew_pkg::*;
#(
  parameter int unsigned NT = 4,
  parameter int unsigned DW = 64,
  parameter int unsigned IW = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NT-1:0]            gnt_i,
  input  logic [NT*DW-1:0]         epn_i,
  input  logic [NT*DW-1:0]         rpn_i,
  input  logic [NT*IW-1:0]         idx_i,
  output logic                     wr_en_o,
  output logic [tid_width(NT)-1:0] wr_tid_o,
  output logic [IW-1:0]            wr_idx_o,
  output logic [DW-1:0]            wr_epn_o,
  output logic [DW-1:0]            wr_rpn_o
);
  localparam int unsigned TW = tid_width(NT);

  logic [TW-1:0] sel_tid;
  logic [IW-1:0] sel_idx;
  logic [DW-1:0] sel_epn, sel_rpn;

  // grant is one-hot, OR-reduce the selected lane
  always_comb begin
    sel_tid = '0;
    sel_idx = '0;
    sel_epn = '0;
    sel_rpn = '0;
    for (int t = 0; t < int'(NT); t++) begin
      if (gnt_i[t]) begin
        sel_tid = sel_tid | TW'(t);
        sel_idx = sel_idx | idx_i[t*IW +: IW];
        sel_epn = sel_epn | epn_i[t*DW +: DW];
        sel_rpn = sel_rpn | rpn_i[t*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o  <= 1'b0;
      wr_tid_o <= '0;
      wr_idx_o <= '0;
      wr_epn_o <= '0;
      wr_rpn_o <= '0;
    end else begin
      wr_en_o <= |gnt_i;
      if (|gnt_i) begin
        wr_tid_o <= sel_tid;
        wr_idx_o <= sel_idx;
        wr_epn_o <= sel_epn;
        wr_rpn_o <= sel_rpn;
      end
    end
  end
endmodule

// File: rtl/aew_entry_writer.sv
module aew_entry_writer
  import aew_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned DATA_W      = 64,
  parameter int unsigned IDX_W       = 4,
  parameter arb_mode_e   ARB_MODE    = ARB_ROTATE,
  localparam int unsigned TID_W      = tid_width(NUM_THREADS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_THREADS-1:0]        req_valid_i,
  input  logic [NUM_THREADS-1:0]        req_ws_i,
  input  logic [NUM_THREADS*DATA_W-1:0] req_data_i,
  input  logic [NUM_THREADS*IDX_W-1:0]  req_idx_i,
  output logic [NUM_THREADS-1:0]        busy_o,
  output logic                          wr_en_o,
  output logic [TID_W-1:0]              wr_tid_o,
  output logic [IDX_W-1:0]              wr_idx_o,
  output logic [DATA_W-1:0]             wr_epn_o,
  output logic [DATA_W-1:0]             wr_rpn_o
);
  logic [NUM_THREADS-1:0]        hold_ld;
  logic [NUM_THREADS-1:0]        commit_req;
  logic [NUM_THREADS-1:0]        grant;
  logic [NUM_THREADS*DATA_W-1:0] hold_val;

  assign hold_ld    = req_valid_i & req_ws_i;
  assign commit_req = req_valid_i & ~req_ws_i;
  assign busy_o     = commit_req & ~grant;

  aew_hold_bank #(.NT(NUM_THREADS), .DW(DATA_W)) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (hold_ld),
    .data_i (req_data_i),
    .hold_o (hold_val)
  );

  aew_commit_arb #(.NT(NUM_THREADS), .MODE(ARB_MODE)) i_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (commit_req),
    .gnt_o  (grant)
  );

  aew_commit_out #(.NT(NUM_THREADS), .DW(DATA_W), .IW(IDX_W)) i_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .gnt_i    (grant),
    .epn_i    (req_data_i),
    .rpn_i    (hold_val),
    .idx_i    (req_idx_i),
    .wr_en_o  (wr_en_o),
    .wr_tid_o (wr_tid_o),
    .wr_idx_o (wr_idx_o),
    .wr_epn_o (wr_epn_o),
    .wr_rpn_o (wr_rpn_o)
  );
endmodule

// File: rtl/aew_writer_chk.sv
module aew_writer_chk #(
  parameter int unsigned NT = 4,
  parameter int unsigned TW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NT-1:0] req_valid_i,
  input logic [NT-1:0] req_ws_i,
  input logic [NT-1:0] busy_o,
  input logic [NT-1:0] grant,
  input logic          wr_en_o,
  input logic [TW-1:0] wr_tid_o
);
  // R5
  single_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));

  // R3
  write_has_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(|(req_valid_i & ~req_ws_i)));

  for (genvar t = 0; t < NT; t++) begin : g_thr
    // R6
    busy_only_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o[t] |-> (req_valid_i[t] && !req_ws_i[t]));

    // R8
    hold_write_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i[t] && req_ws_i[t]) |-> !busy_o[t]);

    // R3
    accepted_commit_writes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i[t] && !req_ws_i[t] && !busy_o[t]) |=> (wr_en_o && wr_tid_o == TW'(t)));
  end
endmodule

bind aew_entry_writer aew_writer_chk #(.NT(NUM_THREADS), .TW(TID_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ws_i    (req_ws_i),
  .busy_o      (busy_o),
  .grant       (grant),
  .wr_en_o     (wr_en_o),
  .wr_tid_o    (wr_tid_o)
);

// File: tb/test_aew_entry_writer.sv
module test_aew_entry_writer;
  localparam int NT = 4;
  localparam int DW = 64;
  localparam int IW = 4;
  localparam int TW = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NT-1:0]      req_valid = '0;
  logic [NT-1:0]      req_ws = '0;
  logic [NT*DW-1:0]   req_data = '0;
  logic [NT*IW-1:0]   req_idx = '0;
  logic [NT-1:0]      busy;
  logic               wr_en;
  logic [TW-1:0]      wr_tid;
  logic [IW-1:0]      wr_idx;
  logic [DW-1:0]      wr_epn, wr_rpn;

  always #4ns clk = ~clk;

  aew_entry_writer #(.NUM_THREADS(NT), .DATA_W(DW), .IDX_W(IW),
                     .ARB_MODE(aew_pkg::ARB_ROTATE)) i_aew_entry_writer (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ws_i(req_ws),
    .req_data_i(req_data), .req_idx_i(req_idx), .busy_o(busy), .wr_en_o(wr_en),
    .wr_tid_o(wr_tid), .wr_idx_o(wr_idx), .wr_epn_o(wr_epn), .wr_rpn_o(wr_rpn));

  int n_cmp = 0;
  int n_bad = 0;

  // drive arrays and reference model
  logic          d_v [NT];
  logic          d_ws[NT];
  logic [DW-1:0] d_dat[NT];
  logic [IW-1:0] d_idx[NT];
  logic [DW-1:0] m_hold[NT];
  int            m_last = NT - 1;
  logic          e_en = 1'b0;
  int            e_tid;
  logic [IW-1:0] e_idx;
  logic [DW-1:0] e_epn, e_rpn;

  task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int exp_grant(input logic [NT-1:0] creq, input int last);
    for (int k = 0; k < NT; k++) begin
      int i;
      i = (last + 1 + k) % NT;
      if (creq[i]) return i;
    end
    return -1;
  endfunction

  task automatic clear_drive();
    for (int t = 0; t < NT; t++) begin
      d_v[t] = 1'b0; d_ws[t] = 1'b0; d_dat[t] = '0; d_idx[t] = '0;
    end
  endtask

  // one cycle: called at negedge
  task automatic step(input string req);
    logic [NT-1:0] creq;
    int g;
    for (int t = 0; t < NT; t++) begin
      req_valid[t] = d_v[t];
      req_ws[t]    = d_ws[t];
      req_data[t*DW +: DW] = d_dat[t];
      req_idx[t*IW +: IW]  = d_idx[t];
      creq[t] = d_v[t] && !d_ws[t];
    end
    #1ns;
    g = exp_grant(creq, m_last);
    for (int t = 0; t < NT; t++)
      chk((d_v[t] && d_ws[t]) ? "R8" : "R6", $sformatf("busy[%0d]", t),
          DW'(busy[t]), DW'(creq[t] && t != g));
    @(posedge clk);
    e_en = (g >= 0);
    if (g >= 0) begin
      e_tid = g; e_idx = d_idx[g]; e_epn = d_dat[g]; e_rpn = m_hold[g];
      m_last = g;
    end
    for (int t = 0; t < NT; t++)
      if (d_v[t] && d_ws[t]) m_hold[t] = d_dat[t];
    @(negedge clk);
    chk(req, "wr_en", DW'(wr_en), DW'(e_en));
    if (e_en) begin
      chk(req, "wr_tid", DW'(wr_tid), DW'(e_tid));
      chk(req, "wr_idx", DW'(wr_idx), DW'(e_idx));
      chk("R3", "wr_epn", wr_epn, e_epn);
      chk((req == "R1") ? "R1" : "R4", "wr_rpn", wr_rpn, e_rpn);
    end
  endtask

  initial begin
    fork
      begin
        #1ms;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    join_none
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int t = 0; t < NT; t++) m_hold[t] = '0;
    clear_drive();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "wr_en", DW'(wr_en), '0);
    chk("R1", "busy", DW'(busy), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: commit without any holding write carries zero
    clear_drive(); d_v[1] = 1; d_dat[1] = 64'h1111_2222_3333_4444; d_idx[1] = 4'd5;
    step("R1");
    // R2: holding load, no array write
    clear_drive(); d_v[2] = 1; d_ws[2] = 1; d_dat[2] = 64'hDEAD_BEEF_CAFE_0002;
    step("R2");
    // R3/R4: commit uses held value
    clear_drive(); d_v[2] = 1; d_dat[2] = 64'hA5A5_0000_0000_0002; d_idx[2] = 4'd9;
    step("R3");
    // R4: reuse without reload
    clear_drive(); d_v[2] = 1; d_dat[2] = 64'h5A5A_0000_0000_0003; d_idx[2] = 4'd10;
    step("R4");
    // R9: thread 0 loads while thread 2 commits
    clear_drive(); d_v[0] = 1; d_ws[0] = 1; d_dat[0] = 64'h0F0F_0F0F_0F0F_0F0F;
    d_v[2] = 1; d_dat[2] = 64'h7777; d_idx[2] = 4'd1;
    step("R9");
    // R7/R5/R6: all four commit, rotating order from last grant (2)
    for (int r = 0; r < NT; r++) begin
      logic [NT-1:0] hold_req;
      hold_req = busy;
      if (r == 0) begin
        clear_drive();
        for (int t = 0; t < NT; t++) begin
          d_v[t] = 1; d_dat[t] = 64'h100 + 64'(t); d_idx[t] = 4'(t + 12);
        end
      end else begin
        for (int t = 0; t < NT; t++) d_v[t] = hold_req[t];
      end
      step("R7");
    end

    // random phase, R5/R6/R8/R9 under mixed traffic
    clear_drive();
    for (int c = 0; c < 3000; c++) begin
      logic [NT-1:0] keep;
      keep = busy;
      for (int t = 0; t < NT; t++) begin
        if (!keep[t]) begin
          d_v[t]   = ($urandom_range(0, 9) < 6);
          d_ws[t]  = $urandom_range(0, 1) == 1;
          d_dat[t] = {$urandom, $urandom};
          d_idx[t] = IW'($urandom);
        end
      end
      step("R5");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule